// File: doc/BRIEF.md
# Port-Mapped Arithmetic Coprocessor

This block hangs off an 8-bit processor I/O bus and gives the processor a 32-bit arithmetic unit. The processor builds each 32-bit operand one byte at a time by writing a group of four consecutive I/O ports. It picks a function by writing a one-byte code to a select port. It then reads the 32-bit answer back one byte at a time through a third group of four ports.

Every function is computed continuously and in parallel: two pass-through paths for checking the operand latches, an 8x8 unsigned multiply and a 16x16 unsigned multiply. The function code only steers which of these outputs reaches the read ports, so an answer is available in the same cycle the operands settle. Address bases, byte width, word size and multiplier widths are parameters.

Top module: `iomath_bridge`

## Requirements
- R1: Reset clears operand A, operand B and the function code to zero; a read of the result right after reset therefore returns zero.
- R2: A write is qualified when chip select is high and both the I/O request and write strobes (active low) are low. The selected register takes the data at the first rising clock edge that sees the qualified strobe, and only once while that strobe stays asserted, even if the data changes.
- R3: Ports 0x60, 0x61, 0x62 and 0x63 write operand A bits 7:0, 15:8, 23:16 and 31:24 respectively.
- R4: Ports 0x64, 0x65, 0x66 and 0x67 write operand B bits 7:0, 15:8, 23:16 and 31:24 respectively.
- R5: A write to port 0x6F stores the full 8-bit function code.
- R6: A read (chip select high, I/O request and read strobes low) of port 0x68, 0x69, 0x6A or 0x6B combinationally returns result bits 7:0, 15:8, 23:16 or 31:24 and raises the read-hit flag.
- R7: For any other port, with chip select low, or with either read or I/O request strobe high, the read-hit flag is low and the read data is zero.
- R8: Function code 0 returns operand A and code 1 returns operand B unchanged.
- R9: Function code 2 returns the unsigned product of A[7:0] and B[7:0], zero-extended to 32 bits.
- R10: Function code 3 returns the 32-bit unsigned product of A[15:0] and B[15:0].
- R11: Every function code from 4 to 255 returns zero.
- R12: Writes to ports outside the two operand groups and the select port, and strobes lacking chip select or I/O request, change neither operand nor the function code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| port_addr | input | 8 | I/O port number |
| wr_data | input | 8 | Byte written by the processor |
| iorq_n | input | 1 | I/O request strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| chip_sel | input | 1 | Enables this block's ports |
| rd_data | output | 8 | Selected result byte, zero when no read hit |
| rd_hit | output | 1 | High while a result port is being read |

## Verification
The assertions assume the bus holds the port number and write byte steady for the whole time a write strobe is low, never lowers read and write together, and releases the strobes between accesses so each access begins with a fresh strobe edge. The bench changes every bus input only on the falling clock edge, holds each access for one full cycle, and keeps idle cycles with all strobes high, so those assumptions hold except in the deliberate held-strobe case, where the data changes while the strobe stays low to show it is captured once.

// File: rtl/iomath_pkg.sv
package iomath_pkg;

   typedef enum logic [7:0] {
      FN_PASS_A = 8'd0,
      FN_PASS_B = 8'd1,
      FN_MUL_LO = 8'd2,
      FN_MUL_HI = 8'd3
   } fn_code_e;

   typedef enum logic [2:0] {
      GRP_NONE,
      GRP_OPA,
      GRP_OPB,
      GRP_FUNC,
      GRP_RES
   } port_grp_e;

endpackage

// File: rtl/iomath_port_dec.sv
module iomath_port_dec
   import iomath_pkg::*;
#(
   parameter int unsigned    WORD_BYTES = 4,
   parameter logic [7:0]     OPA_BASE   = 8'h60,
   parameter logic [7:0]     OPB_BASE   = 8'h64,
   parameter logic [7:0]     RES_BASE   = 8'h68,
   parameter logic [7:0]     FUNC_PORT  = 8'h6F,
   localparam int unsigned   LANE_W     = (WORD_BYTES > 1) ? $clog2(WORD_BYTES) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [7:0]        port_addr,
   input  logic              iorq_n,
   input  logic              rd_n,
   input  logic              wr_n,
   input  logic              chip_sel,
   output logic              wr_pulse,
   output port_grp_e         wr_grp,
   output logic [LANE_W-1:0] wr_lane,
   output logic              rd_hit,
   output logic [LANE_W-1:0] rd_lane
);

   function automatic logic in_window(input logic [7:0] a, input logic [7:0] base);
      return ({1'b0, a} >= {1'b0, base}) && ({1'b0, a} < ({1'b0, base} + 9'(WORD_BYTES)));
   endfunction

   logic strobe_w;
   logic strobe_q;

   assign strobe_w = chip_sel && !iorq_n && !wr_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) strobe_q <= 1'b0;
      else        strobe_q <= strobe_w;
   end

   assign wr_pulse = strobe_w && !strobe_q;

   always_comb begin
      wr_grp  = GRP_NONE;
      wr_lane = '0;
      if (in_window(port_addr, OPA_BASE)) begin
         wr_grp  = GRP_OPA;
         wr_lane = LANE_W'(port_addr - OPA_BASE);
      end else if (in_window(port_addr, OPB_BASE)) begin
         wr_grp  = GRP_OPB;
         wr_lane = LANE_W'(port_addr - OPB_BASE);
      end else if (port_addr == FUNC_PORT) begin
         wr_grp  = GRP_FUNC;
      end
   end

   assign rd_hit  = chip_sel && !iorq_n && !rd_n && in_window(port_addr, RES_BASE);
   assign rd_lane = LANE_W'(port_addr - RES_BASE);

   // R2
   wr_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_pulse |=> !wr_pulse);

   // R7
   rd_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !chip_sel |-> !rd_hit);

endmodule

// File: rtl/iomath_lane_reg.sv
module iomath_lane_reg #(
   parameter int unsigned    BYTE_W     = 8,
   parameter int unsigned    WORD_BYTES = 4,
   localparam int unsigned   LANE_W     = (WORD_BYTES > 1) ? $clog2(WORD_BYTES) : 1,
   localparam int unsigned   WORD_W     = BYTE_W * WORD_BYTES
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [LANE_W-1:0] lane,
   input  logic [BYTE_W-1:0] din,
   output logic [WORD_W-1:0] q
);

   logic [BYTE_W-1:0] bytes_q [WORD_BYTES];

   for (genvar i = 0; i < WORD_BYTES; i++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                          bytes_q[i] <= '0;
         else if (we && lane == LANE_W'(i))   bytes_q[i] <= din;
      end
      assign q[i*BYTE_W +: BYTE_W] = bytes_q[i];

      // R3
      lane_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (we && lane == LANE_W'(i)) |=> bytes_q[i] == $past(din));
   end

   // R12
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> $stable(q));

endmodule

// File: rtl/iomath_umul.sv
module iomath_umul #(
   parameter int unsigned IN_W  = 8,
   parameter int unsigned OUT_W = 32
) (
   input  logic [IN_W-1:0]  a,
   input  logic [IN_W-1:0]  b,
   output logic [OUT_W-1:0] p
);

   if (OUT_W < 2 * IN_W) begin : g_bad
      $error("iomath_umul: OUT_W must hold the full product");
   end else begin : g_full
      logic [2*IN_W-1:0] full_w;
      assign full_w = a * b;
      assign p      = OUT_W'(full_w);
   end

endmodule

// File: rtl/iomath_res_mux.sv
module iomath_res_mux
   import iomath_pkg::*;
#(
   parameter int unsigned WORD_W = 32,
   parameter int unsigned CODE_W = 8
) (
   input  logic [CODE_W-1:0] func,
   input  logic [WORD_W-1:0] op_a,
   input  logic [WORD_W-1:0] op_b,
   input  logic [WORD_W-1:0] mul_lo,
   input  logic [WORD_W-1:0] mul_hi,
   output logic [WORD_W-1:0] result
);

   always_comb begin
      case (func)
         CODE_W'(FN_PASS_A): result = op_a;
         CODE_W'(FN_PASS_B): result = op_b;
         CODE_W'(FN_MUL_LO): result = mul_lo;
         CODE_W'(FN_MUL_HI): result = mul_hi;
         default:            result = '0;
      endcase
   end

endmodule

// File: rtl/iomath_bridge.sv
module iomath_bridge
   import iomath_pkg::*;
#(
   parameter int unsigned  BYTE_W     = 8,
   parameter int unsigned  WORD_BYTES = 4,
   parameter int unsigned  NARROW_W   = 8,
   parameter int unsigned  WIDE_W     = 16,
   parameter logic [7:0]   OPA_BASE   = 8'h60,
   parameter logic [7:0]   OPB_BASE   = 8'h64,
   parameter logic [7:0]   RES_BASE   = 8'h68,
   parameter logic [7:0]   FUNC_PORT  = 8'h6F
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [7:0]        port_addr,
   input  logic [BYTE_W-1:0] wr_data,
   input  logic              iorq_n,
   input  logic              rd_n,
   input  logic              wr_n,
   input  logic              chip_sel,
   output logic [BYTE_W-1:0] rd_data,
   output logic              rd_hit
);

   localparam int unsigned WORD_W = BYTE_W * WORD_BYTES;
   localparam int unsigned LANE_W = (WORD_BYTES > 1) ? $clog2(WORD_BYTES) : 1;

   if (WORD_BYTES < 2) begin : g_chk_bytes
      $error("iomath_bridge: WORD_BYTES must be at least 2");
   end
   if (2 * WIDE_W > WORD_W || NARROW_W > WIDE_W) begin : g_chk_mul
      $error("iomath_bridge: multiplier widths do not fit the result word");
   end
   if (BYTE_W < 8) begin : g_chk_code
      $error("iomath_bridge: function code needs at least 8 bits");
   end

   logic              wr_pulse;
   port_grp_e         wr_grp;
   logic [LANE_W-1:0] wr_lane;
   logic [LANE_W-1:0] rd_lane;
   logic [WORD_W-1:0] op_a, op_b, mul_lo, mul_hi, result;
   logic [BYTE_W-1:0] func_q;

   iomath_port_dec #(
      .WORD_BYTES (WORD_BYTES),
      .OPA_BASE   (OPA_BASE),
      .OPB_BASE   (OPB_BASE),
      .RES_BASE   (RES_BASE),
      .FUNC_PORT  (FUNC_PORT)
   ) dec_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .port_addr (port_addr),
      .iorq_n    (iorq_n),
      .rd_n      (rd_n),
      .wr_n      (wr_n),
      .chip_sel  (chip_sel),
      .wr_pulse  (wr_pulse),
      .wr_grp    (wr_grp),
      .wr_lane   (wr_lane),
      .rd_hit    (rd_hit),
      .rd_lane   (rd_lane)
   );

   iomath_lane_reg #(.BYTE_W(BYTE_W), .WORD_BYTES(WORD_BYTES)) opa_i (
      .clk (clk), .rst_n (rst_n),
      .we  (wr_pulse && wr_grp == GRP_OPA),
      .lane(wr_lane), .din (wr_data), .q (op_a)
   );

   iomath_lane_reg #(.BYTE_W(BYTE_W), .WORD_BYTES(WORD_BYTES)) opb_i (
      .clk (clk), .rst_n (rst_n),
      .we  (wr_pulse && wr_grp == GRP_OPB),
      .lane(wr_lane), .din (wr_data), .q (op_b)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 func_q <= '0;
      else if (wr_pulse && wr_grp == GRP_FUNC)    func_q <= wr_data;
   end

   iomath_umul #(.IN_W(NARROW_W), .OUT_W(WORD_W)) mul_lo_i (
      .a (op_a[NARROW_W-1:0]), .b (op_b[NARROW_W-1:0]), .p (mul_lo)
   );

   iomath_umul #(.IN_W(WIDE_W), .OUT_W(WORD_W)) mul_hi_i (
      .a (op_a[WIDE_W-1:0]), .b (op_b[WIDE_W-1:0]), .p (mul_hi)
   );

   iomath_res_mux #(.WORD_W(WORD_W), .CODE_W(BYTE_W)) mux_i (
      .func   (func_q),
      .op_a   (op_a),
      .op_b   (op_b),
      .mul_lo (mul_lo),
      .mul_hi (mul_hi),
      .result (result)
   );

   assign rd_data = rd_hit ? result[rd_lane*BYTE_W +: BYTE_W] : '0;

   // R8
   pass_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_hit && func_q == BYTE_W'(FN_PASS_A) && port_addr == RES_BASE)
         |-> rd_data == op_a[BYTE_W-1:0]);

   // R11
   undef_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_hit && func_q > BYTE_W'(FN_MUL_HI)) |-> rd_data == '0);

endmodule

// File: tb/iomath_bridge_tb_top.sv
module iomath_bridge_tb_top;

   localparam int CLK_P = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] port_addr = 8'h00;
   logic [7:0] wr_data = 8'h00;
   logic       iorq_n = 1'b1;
   logic       rd_n = 1'b1;
   logic       wr_n = 1'b1;
   logic       chip_sel = 1'b0;
   logic [7:0] rd_data;
   logic       rd_hit;

   int checks = 0;
   int fails  = 0;

   always #(CLK_P/2) clk = ~clk;

   iomath_bridge dut_i (
      .clk (clk), .rst_n (rst_n), .port_addr (port_addr), .wr_data (wr_data),
      .iorq_n (iorq_n), .rd_n (rd_n), .wr_n (wr_n), .chip_sel (chip_sel),
      .rd_data (rd_data), .rd_hit (rd_hit)
   );

   // Behavioural reference model
   logic [31:0] m_a = 0, m_b = 0;
   logic [7:0]  m_f = 0;
   logic        m_prev = 0;

   function automatic logic [31:0] m_result();
      case (m_f)
         8'd0: return m_a;
         8'd1: return m_b;
         8'd2: return 32'(m_a[7:0]) * 32'(m_b[7:0]);
         8'd3: return 32'(m_a[15:0]) * 32'(m_b[15:0]);
         default: return 32'd0;
      endcase
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   always @(posedge clk) begin
      logic stb;
      logic [31:0] res;
      logic exp_hit;
      logic [7:0] exp_d;
      if (!rst_n) begin
         m_a = 0; m_b = 0; m_f = 0; m_prev = 0;
      end else begin
         stb = chip_sel && !iorq_n && !wr_n;
         if (stb && !m_prev) begin
            if (port_addr >= 8'h60 && port_addr <= 8'h63) m_a[(port_addr-8'h60)*8 +: 8] = wr_data;
            else if (port_addr >= 8'h64 && port_addr <= 8'h67) m_b[(port_addr-8'h64)*8 +: 8] = wr_data;
            else if (port_addr == 8'h6F) m_f = wr_data;
         end
         m_prev = stb;
      end
      #2;
      if (rst_n) begin
         res = m_result();
         exp_hit = chip_sel && !iorq_n && !rd_n && port_addr >= 8'h68 && port_addr <= 8'h6B;
         exp_d = exp_hit ? res[(port_addr-8'h68)*8 +: 8] : 8'h00;
         chk("R6 R7 per-cycle model", {23'd0, rd_hit, rd_data}, {23'd0, exp_hit, exp_d});
      end
   end

   task automatic idle();
      @(negedge clk);
      iorq_n = 1; rd_n = 1; wr_n = 1; chip_sel = 0;
   endtask

   task automatic wr_port(input logic [7:0] a, input logic [7:0] d,
                          input logic cs = 1, input logic iorq = 0);
      @(negedge clk);
      port_addr = a; wr_data = d; chip_sel = cs; iorq_n = iorq; wr_n = 0; rd_n = 1;
      idle();
   endtask

   task automatic rd_port(input logic [7:0] a, output logic [7:0] d, output logic hit,
                          input logic cs = 1, input logic iorq = 0, input logic rd = 0);
      @(negedge clk);
      port_addr = a; chip_sel = cs; iorq_n = iorq; rd_n = rd; wr_n = 1;
      #3;
      d = rd_data; hit = rd_hit;
      idle();
   endtask

   task automatic rd_word(input string tag, input logic [31:0] exp);
      logic [31:0] w;
      logic [7:0]  d;
      logic        h;
      logic        all_hit;
      all_hit = 1;
      for (int i = 0; i < 4; i++) begin
         rd_port(8'h68 + 8'(i), d, h);
         w[i*8 +: 8] = d;
         all_hit &= h;
      end
      chk(tag, w, exp);
      chk({tag, " hit"}, 32'(all_hit), 32'd1);
   endtask

   task automatic wr_word(input logic [7:0] base, input logic [31:0] v);
      for (int i = 0; i < 4; i++) wr_port(base + 8'(i), v[i*8 +: 8]);
   endtask

   initial begin
      #(CLK_P * 100000);
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      logic [7:0] d;
      logic       h;
      repeat (3) @(negedge clk);
      rst_n = 1;
      repeat (2) @(negedge clk);

      // R1: reset state, code 0 selects A which is zero
      rd_word("R1 result after reset", 32'h0);
      wr_port(8'h6F, 8'd1);
      rd_word("R1 operand B after reset", 32'h0);
      wr_port(8'h6F, 8'd0);

      // R3, R6: byte lanes of A, LSB at lowest port
      wr_word(8'h60, 32'hCAFE0102);
      rd_word("R3 R8 operand A loopback", 32'hCAFE0102);
      rd_port(8'h68, d, h);
      chk("R6 lane 0x68 is bits 7:0", 32'(d), 32'h02);
      rd_port(8'h6B, d, h);
      chk("R6 lane 0x6B is bits 31:24", 32'(d), 32'hCA);

      // R4, R5, R8
      wr_word(8'h64, 32'h5A5A0304);
      wr_port(8'h6F, 8'd1);
      rd_word("R4 R5 R8 operand B loopback", 32'h5A5A0304);

      // R9, R10
      wr_port(8'h6F, 8'd2);
      rd_word("R9 8x8 product", 32'h00000008);
      wr_port(8'h6F, 8'd3);
      rd_word("R10 16x16 product", 32'h00030A08);

      // R11
      wr_port(8'h6F, 8'd4);
      rd_word("R11 code 4 zero", 32'h0);
      wr_port(8'h6F, 8'hFF);
      rd_word("R11 code 255 zero", 32'h0);

      // R9, R10 boundary: all-ones low halves
      wr_port(8'h60, 8'hFF); wr_port(8'h61, 8'hFF);
      wr_port(8'h64, 8'hFF); wr_port(8'h65, 8'hFF);
      wr_port(8'h6F, 8'd3);
      rd_word("R10 max 16x16 product", 32'hFFFE0001);
      wr_port(8'h6F, 8'd2);
      rd_word("R9 max 8x8 product", 32'h0000FE01);

      // R12: ignored writes
      wr_port(8'h6F, 8'd0);
      wr_port(8'h68, 8'h11);
      wr_port(8'h6C, 8'h22);
      wr_port(8'h5F, 8'h33);
      wr_port(8'h60, 8'h44, 1'b0, 1'b0);
      wr_port(8'h60, 8'h55, 1'b1, 1'b1);
      wr_port(8'h6F, 8'd1, 1'b0, 1'b0);
      rd_word("R12 operand A untouched", 32'hCAFEFFFF);
      wr_port(8'h6F, 8'd1);
      rd_word("R12 operand B untouched", 32'h5A5AFFFF);
      wr_port(8'h6F, 8'd0);

      // R2: held strobe writes once
      @(negedge clk);
      port_addr = 8'h60; wr_data = 8'h33; chip_sel = 1; iorq_n = 0; wr_n = 0;
      @(negedge clk);
      wr_data = 8'h44;
      @(negedge clk);
      wr_data = 8'h55;
      idle();
      rd_word("R2 held strobe captured once", 32'hCAFEFF33);

      // R7: no hit outside the result ports or without qualifiers
      rd_port(8'h6F, d, h);
      chk("R7 port 0x6F read no hit", {23'd0, h, d}, 32'h0);
      rd_port(8'h67, d, h);
      chk("R7 port 0x67 read no hit", {23'd0, h, d}, 32'h0);
      rd_port(8'h68, d, h, 1'b0);
      chk("R7 chip select low", {23'd0, h, d}, 32'h0);
      rd_port(8'h69, d, h, 1'b1, 1'b1);
      chk("R7 iorq high", {23'd0, h, d}, 32'h0);
      rd_port(8'h6A, d, h, 1'b1, 1'b0, 1'b1);
      chk("R7 rd high", {23'd0, h, d}, 32'h0);

      // R1: reset mid-run
      wr_port(8'h6F, 8'd3);
      @(negedge clk); rst_n = 0;
      @(negedge clk); @(negedge clk); rst_n = 1;
      rd_word("R1 reset clears operands and code", 32'h0);

      repeat (3) @(negedge clk);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule